// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block collects interrupt requests from five sources for a small 8-bit processor core and picks one of them. The sources are two active-low external pins, two timer overflow pulses and a serial unit that has separate receive and transmit events. Software programs a master/per-source enable register, a per-source priority bit register and a trigger-type register through a simple register port. The controller offers the winning request to the core as a request line with a 16-bit vector address, and the core answers with an acknowledge.

The controller tracks which of the two priority levels is in service. A high-priority source can interrupt a low-priority routine. Nothing can interrupt a high-priority routine. The in-service state for a level is released only by a return-from-interrupt strobe. The controller samples the external pins on a machine-cycle tick. Each pin either requests while it is held low, or latches a flag on a falling edge. On acknowledge the controller clears a source's flag only where the trigger type calls for it.

Top module: `vic_ctrl`

## Requirements
- R1: After a synchronous reset, `irq_req` is 0, `irq_vec` is 0000h, all four registers read 00h and neither level is in service.
- R2: A source can request only when bit 7 (master enable) and its own bit of the enable register are both 1. The bit positions are: bit 0 external 0, bit 1 timer 0, bit 2 external 1, bit 3 timer 1, bit 4 serial.
- R3: The vector is 0003h + 8 × source index, with index 0 external 0, 1 timer 0, 2 external 1, 3 timer 1, 4 serial. This gives 0003h, 000Bh, 0013h, 001Bh and 0023h.
- R4: Among pending, enabled sources of the same priority level, the lowest source index wins.
- R5: A source whose priority register bit (same bit positions as R2) is 1 beats every low-priority source. It is also offered while a low-priority routine is in service.
- R6: An acknowledge drops `irq_req` on the following cycle. While a high-level routine is in service, no request is offered. While a low-level routine is in service, only high-priority requests are offered.
- R7: When trigger-type bit (register 2, bit 0 for external 0, bit 1 for external 1) is 0, the pin requests while its sampled value is 0. Nothing is latched, and the request returns after a return-from-interrupt while the pin stays low.
- R8: When the trigger-type bit is 1, a sampled 1 followed by a sampled 0 latches the pin's flag. Pins are sampled only on cycles with `cyc_tick` high. Acknowledging that source clears the flag.
- R9: A timer overflow pulse sets the timer's flag, and acknowledging that timer clears the flag.
- R10: The serial request is receive flag OR transmit flag. Acknowledge never clears these flags. Only a write to the flag register clears them. The flag register (register 3) layout is: bit 0 external 0 edge, 1 timer 0, 2 external 1 edge, 3 timer 1, 4 receive, 5 transmit.
- R11: Only `irq_reti` releases in-service state. Each strobe releases the high level if it is set, and otherwise the low level. Without it, a level stays blocked indefinitely.
- R12: `reg_rdata` shows the register selected by `reg_sel` (0 enable, 1 priority, 2 trigger type, 3 flags) one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_tick | input | 1 | Machine-cycle strobe for pin sampling |
| ext_n | input | 2 | External request pins, active low |
| tmr_ovf | input | 2 | Timer overflow pulses |
| ser_rx | input | 1 | Serial receive-complete pulse |
| ser_tx | input | 1 | Serial transmit-complete pulse |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| irq_req | output | 1 | Request to the core |
| irq_vec | output | 16 | Vector address of the offered source |
| irq_ack | input | 1 | Core acknowledge of the offered vector |
| irq_reti | input | 1 | Return-from-interrupt strobe |

## Verification
The bench targets the places where the level logic is most likely to go wrong. If a low-level routine is left in service, a second low request could be wrongly taken. A high request arriving in that state could be wrongly refused. One return strobe could release both levels instead of one. Skipping the return entirely must keep requests blocked. On flags, the checks catch three faults: clearing the serial flags on acknowledge, latching a held-low pin that is in level mode, and sampling an edge on a cycle without a tick. A wrong tie order or vector stride would show up as a wrong vector in the table rows.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int NSRC   = 5;
  localparam int SRC_IW = $clog2(NSRC);
  localparam int NFLAG  = 6;

  typedef enum logic [1:0] {
    SEL_EN   = 2'd0,
    SEL_PRIO = 2'd1,
    SEL_MODE = 2'd2,
    SEL_FLAG = 2'd3
  } regsel_e;

  // flag register bit positions
  localparam int F_EXT0 = 0;
  localparam int F_TMR0 = 1;
  localparam int F_EXT1 = 2;
  localparam int F_TMR1 = 3;
  localparam int F_RX   = 4;
  localparam int F_TX   = 5;
endpackage

// File: rtl/vic_pin_sampler.sv
module vic_pin_sampler #(
  parameter int NPIN = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic [NPIN-1:0] pin_n,
  output logic [NPIN-1:0] level,
  output logic [NPIN-1:0] fall
);
  logic [NPIN-1:0] samp_q;

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    always_ff @(posedge clk) begin
      if (rst)       samp_q[g] <= 1'b1;
      else if (tick) samp_q[g] <= pin_n[g];
    end
    assign level[g] = ~samp_q[g];
    assign fall[g]  = tick & samp_q[g] & ~pin_n[g];

    // R8
    edge_sample_chk: assert property (@(posedge clk) disable iff (rst)
      fall[g] |=> level[g]);
  end
endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter
  import vic_pkg::*;
#(
  parameter int N = NSRC,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0] pend,
  input  logic [N-1:0] ena,
  input  logic [N-1:0] prio,
  input  logic         ea,
  input  logic         blk_hi,
  input  logic         blk_lo,
  output logic         valid,
  output logic [W-1:0] idx,
  output logic         sel_hi
);
  logic [N-1:0] elig, hi_m, lo_m, pick;
  logic         use_hi;

  assign elig   = pend & ena & {N{ea}};
  assign hi_m   = elig & prio;
  assign lo_m   = elig & ~prio;
  assign use_hi = !blk_hi && (|hi_m);
  assign pick   = use_hi ? hi_m : ((!blk_hi && !blk_lo) ? lo_m : '0);

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pick[i]) idx = W'(i);
    end
    valid  = |pick;
    sel_hi = use_hi;
  end
endmodule

// File: rtl/vic_level_track.sv
module vic_level_track (
  input  logic clk,
  input  logic rst,
  input  logic take,
  input  logic take_hi,
  input  logic reti,
  output logic isv_hi,
  output logic isv_lo
);
  always_ff @(posedge clk) begin
    if (rst) begin
      isv_hi <= 1'b0;
      isv_lo <= 1'b0;
    end else if (take) begin
      if (take_hi) isv_hi <= 1'b1;
      else         isv_lo <= 1'b1;
    end else if (reti) begin
      if (isv_hi) isv_hi <= 1'b0;
      else        isv_lo <= 1'b0;
    end
  end

  // R11
  release_one_chk: assert property (@(posedge clk) disable iff (rst)
    (reti && !take && isv_hi) |=> (!isv_hi && isv_lo == $past(isv_lo)));
  // R11
  hold_state_chk: assert property (@(posedge clk) disable iff (rst)
    (!reti && !take) |=> ($stable(isv_hi) && $stable(isv_lo)));
  // R6
  low_take_chk: assert property (@(posedge clk) disable iff (rst)
    (take && !take_hi) |-> (!isv_lo && !isv_hi));
endmodule

// File: rtl/vic_ctrl.sv
module vic_ctrl
  import vic_pkg::*;
#(
  parameter int             DW         = 8,
  parameter int             VW         = 16,
  parameter logic [VW-1:0]  VEC_BASE   = 16'h0003,
  parameter logic [VW-1:0]  VEC_STRIDE = 16'h0008,
  localparam int            EA_BIT     = DW - 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cyc_tick,
  input  logic [1:0]    ext_n,
  input  logic [1:0]    tmr_ovf,
  input  logic          ser_rx,
  input  logic          ser_tx,
  input  logic          reg_we,
  input  logic [1:0]    reg_sel,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq_req,
  output logic [VW-1:0] irq_vec,
  input  logic          irq_ack,
  input  logic          irq_reti
);
  logic [DW-1:0]     en_q, pr_q, md_q;
  logic [NFLAG-1:0]  flag_q, flag_d, flag_set, flag_clr, flag_base;
  logic [1:0]        lvl, fall;
  logic [NSRC-1:0]   pend;
  logic              valid_c, hi_c, hi_q, take, isv_hi, isv_lo;
  logic [SRC_IW-1:0] idx_c, idx_q;
  logic [VW-1:0]     vec_c;
  regsel_e           sel;

  assign sel  = regsel_e'(reg_sel);
  assign take = irq_ack & irq_req;

  // configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= '0;
      pr_q <= '0;
      md_q <= '0;
    end else if (reg_we) begin
      case (sel)
        SEL_EN:   en_q <= reg_wdata;
        SEL_PRIO: pr_q <= reg_wdata;
        SEL_MODE: md_q <= reg_wdata;
        default:  ;
      endcase
    end
  end

  vic_pin_sampler #(.NPIN(2)) u_pins (
    .clk   (clk),
    .rst   (rst),
    .tick  (cyc_tick),
    .pin_n (ext_n),
    .level (lvl),
    .fall  (fall)
  );

  // flag update: software write, then clear on acknowledge, then new events
  always_comb begin
    flag_clr = '0;
    if (take) begin
      case (idx_q)
        SRC_IW'(0): flag_clr[F_EXT0] = md_q[0];
        SRC_IW'(1): flag_clr[F_TMR0] = 1'b1;
        SRC_IW'(2): flag_clr[F_EXT1] = md_q[1];
        SRC_IW'(3): flag_clr[F_TMR1] = 1'b1;
        default:    ;
      endcase
    end
    flag_set = '0;
    flag_set[F_EXT0] = fall[0] & md_q[0];
    flag_set[F_TMR0] = tmr_ovf[0];
    flag_set[F_EXT1] = fall[1] & md_q[1];
    flag_set[F_TMR1] = tmr_ovf[1];
    flag_set[F_RX]   = ser_rx;
    flag_set[F_TX]   = ser_tx;
    flag_base = (reg_we && sel == SEL_FLAG) ? reg_wdata[NFLAG-1:0] : flag_q;
    flag_d    = (flag_base & ~flag_clr) | flag_set;
  end

  always_ff @(posedge clk) begin
    if (rst) flag_q <= '0;
    else     flag_q <= flag_d;
  end

  assign pend[0] = md_q[0] ? flag_q[F_EXT0] : lvl[0];
  assign pend[1] = flag_q[F_TMR0];
  assign pend[2] = md_q[1] ? flag_q[F_EXT1] : lvl[1];
  assign pend[3] = flag_q[F_TMR1];
  assign pend[4] = flag_q[F_RX] | flag_q[F_TX];

  vic_arbiter #(.N(NSRC)) u_arb (
    .pend   (pend),
    .ena    (en_q[NSRC-1:0]),
    .prio   (pr_q[NSRC-1:0]),
    .ea     (en_q[EA_BIT]),
    .blk_hi (isv_hi),
    .blk_lo (isv_lo),
    .valid  (valid_c),
    .idx    (idx_c),
    .sel_hi (hi_c)
  );

  assign vec_c = VEC_BASE + VW'(idx_c) * VEC_STRIDE;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req <= 1'b0;
      irq_vec <= '0;
      idx_q   <= '0;
      hi_q    <= 1'b0;
    end else begin
      irq_req <= valid_c & ~take;
      irq_vec <= (valid_c & ~take) ? vec_c : '0;
      idx_q   <= idx_c;
      hi_q    <= hi_c;
    end
  end

  vic_level_track u_lvl (
    .clk     (clk),
    .rst     (rst),
    .take    (take),
    .take_hi (hi_q),
    .reti    (irq_reti),
    .isv_hi  (isv_hi),
    .isv_lo  (isv_lo)
  );

  // registered read port
  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else begin
      case (sel)
        SEL_EN:   reg_rdata <= en_q;
        SEL_PRIO: reg_rdata <= pr_q;
        SEL_MODE: reg_rdata <= md_q;
        default:  reg_rdata <= DW'(flag_q);
      endcase
    end
  end

  // R3
  vec_slot_chk: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (((irq_vec - VEC_BASE) % VEC_STRIDE) == '0 &&
                 irq_vec < VEC_BASE + VW'(NSRC) * VEC_STRIDE));
  // R2
  master_gate_chk: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> $past(en_q[EA_BIT]));
  // R6
  hi_block_chk: assert property (@(posedge clk) disable iff (rst)
    isv_hi |-> !irq_req);
  // R6
  ack_drop_chk: assert property (@(posedge clk) disable iff (rst)
    take |=> !irq_req);
  // R10
  ser_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (take && idx_q == SRC_IW'(4) && !(reg_we && sel == SEL_FLAG))
      |=> ((flag_q[F_TX:F_RX] & $past(flag_q[F_TX:F_RX])) == $past(flag_q[F_TX:F_RX])));
endmodule

// File: tb/vic_ctrl_tb.sv
`timescale 1ns/1ps
module vic_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst, cyc_tick, ser_rx, ser_tx, reg_we, irq_ack, irq_reti;
  logic [1:0]  ext_n, tmr_ovf, reg_sel;
  logic [7:0]  reg_wdata, reg_rdata, rv;
  logic        irq_req;
  logic [15:0] irq_vec;
  int          checks = 0;
  int          errors = 0;

  always #2.5 clk = ~clk;

  vic_ctrl u_dut (
    .clk(clk), .rst(rst), .cyc_tick(cyc_tick), .ext_n(ext_n), .tmr_ovf(tmr_ovf),
    .ser_rx(ser_rx), .ser_tx(ser_tx), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_req(irq_req),
    .irq_vec(irq_vec), .irq_ack(irq_ack), .irq_reti(irq_reti)
  );

  typedef struct packed {
    logic [7:0]  en;
    logic [7:0]  pr;
    logic [1:0]  tm;
    logic        rx;
    logic        tx;
    logic [1:0]  lo;
    logic        req;
    logic [15:0] vec;
  } row_t;

  localparam int NROW = 10;
  localparam row_t ROWS [NROW] = '{
    '{8'h9F, 8'h00, 2'b11, 1'b0, 1'b0, 2'b00, 1'b1, 16'h000B}, // R4 timer0 over timer1
    '{8'h9F, 8'h08, 2'b11, 1'b0, 1'b0, 2'b00, 1'b1, 16'h001B}, // R5 high timer1
    '{8'h1F, 8'h00, 2'b01, 1'b0, 1'b0, 2'b00, 1'b0, 16'h0000}, // R2 master off
    '{8'h82, 8'h00, 2'b10, 1'b0, 1'b0, 2'b00, 1'b0, 16'h0000}, // R2 own enable off
    '{8'h90, 8'h00, 2'b00, 1'b1, 1'b0, 2'b00, 1'b1, 16'h0023}, // R10 receive
    '{8'h90, 8'h00, 2'b00, 1'b0, 1'b1, 2'b00, 1'b1, 16'h0023}, // R10 transmit
    '{8'h84, 8'h00, 2'b00, 1'b0, 1'b0, 2'b10, 1'b1, 16'h0013}, // R7 ext1 level
    '{8'h9F, 8'h00, 2'b00, 1'b0, 1'b1, 2'b01, 1'b1, 16'h0003}, // R4 ext0 over serial
    '{8'h9F, 8'h10, 2'b00, 1'b0, 1'b1, 2'b01, 1'b1, 16'h0023}, // R5 high serial
    '{8'h9F, 8'h1F, 2'b10, 1'b0, 1'b0, 2'b10, 1'b1, 16'h0013}  // R4 tie among high
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; cyc_tick = 1'b1; ext_n = 2'b11; tmr_ovf = 2'b00;
    ser_rx = 1'b0; ser_tx = 1'b0; reg_we = 1'b0; reg_sel = 2'd0;
    reg_wdata = 8'h00; irq_ack = 1'b0; irq_reti = 1'b0;
    repeat (3) step();
    rst = 1'b0;
    step();
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    reg_we = 1'b1; reg_sel = s; reg_wdata = d;
    step();
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [7:0] d);
    reg_sel = s;
    step();
    d = reg_rdata;
  endtask

  task automatic pulse(input logic [1:0] tm, input logic rx, input logic tx);
    tmr_ovf = tm; ser_rx = rx; ser_tx = tx;
    step();
    tmr_ovf = 2'b00; ser_rx = 1'b0; ser_tx = 1'b0;
  endtask

  task automatic ack();
    irq_ack = 1'b1;
    step();
    irq_ack = 1'b0;
  endtask

  task automatic reti();
    irq_reti = 1'b1;
    step();
    irq_reti = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1 reset state
    do_reset();
    chk("R1 req", {15'd0, irq_req}, 16'd0);
    chk("R1 vec", irq_vec, 16'h0000);
    for (int s = 0; s < 4; s++) begin
      rd(2'(s), rv);
      chk("R1 reg", {8'd0, rv}, 16'd0);
    end

    // R12 read back
    wr(2'd1, 8'h15);
    rd(2'd1, rv);
    chk("R12 prio", {8'd0, rv}, 16'h0015);
    wr(2'd0, 8'hA5);
    rd(2'd0, rv);
    chk("R12 enable", {8'd0, rv}, 16'h00A5);

    // table of arbitration vectors
    for (int r = 0; r < NROW; r++) begin
      do_reset();
      wr(2'd0, ROWS[r].en);
      wr(2'd1, ROWS[r].pr);
      ext_n = ~ROWS[r].lo;
      pulse(ROWS[r].tm, ROWS[r].rx, ROWS[r].tx);
      step();
      chk("R3 table req", {15'd0, irq_req}, {15'd0, ROWS[r].req});
      chk("R3 table vec", irq_vec, ROWS[r].vec);
    end

    // R9 R6 R5 R11 R10 nesting sequence
    do_reset();
    wr(2'd0, 8'h9F);
    pulse(2'b01, 1'b0, 1'b0);
    step();
    chk("R9 timer0 vec", irq_vec, 16'h000B);
    ack();
    chk("R6 ack drops req", {15'd0, irq_req}, 16'd0);
    rd(2'd3, rv);
    chk("R9 timer0 flag cleared", {8'd0, rv}, 16'h0000);
    pulse(2'b10, 1'b0, 1'b0);
    step();
    chk("R6 low blocks low", {15'd0, irq_req}, 16'd0);
    repeat (6) step();
    chk("R11 no return keeps block", {15'd0, irq_req}, 16'd0);
    wr(2'd1, 8'h08);
    step();
    chk("R5 preempt req", {15'd0, irq_req}, 16'd1);
    chk("R5 preempt vec", irq_vec, 16'h001B);
    ack();
    pulse(2'b00, 1'b1, 1'b0);
    step();
    chk("R6 high blocks all", {15'd0, irq_req}, 16'd0);
    reti();
    step();
    chk("R11 one level released", {15'd0, irq_req}, 16'd0);
    reti();
    step();
    chk("R11 second return req", {15'd0, irq_req}, 16'd1);
    chk("R11 second return vec", irq_vec, 16'h0023);
    ack();
    rd(2'd3, rv);
    chk("R10 serial flag kept", {8'd0, rv}, 16'h0010);
    wr(2'd3, 8'h00);
    reti();
    step();
    chk("R10 software clear", {15'd0, irq_req}, 16'd0);

    // R8 falling edge mode
    do_reset();
    wr(2'd2, 8'h01);
    wr(2'd0, 8'h81);
    cyc_tick = 1'b0;
    ext_n[0] = 1'b0;
    repeat (3) step();
    chk("R8 no tick no edge", {15'd0, irq_req}, 16'd0);
    cyc_tick = 1'b1;
    step();
    step();
    chk("R8 edge vec", irq_vec, 16'h0003);
    ext_n[0] = 1'b1;
    step();
    step();
    chk("R8 edge latched", {15'd0, irq_req}, 16'd1);
    ack();
    rd(2'd3, rv);
    chk("R8 edge flag cleared", {8'd0, rv}, 16'h0000);
    reti();
    step();
    chk("R8 no second edge", {15'd0, irq_req}, 16'd0);

    // R7 level mode
    do_reset();
    wr(2'd0, 8'h84);
    ext_n[1] = 1'b0;
    step();
    step();
    chk("R7 level vec", irq_vec, 16'h0013);
    ack();
    reti();
    step();
    chk("R7 level refires", {15'd0, irq_req}, 16'd1);
    rd(2'd3, rv);
    chk("R7 nothing latched", {8'd0, rv}, 16'h0000);
    ext_n[1] = 1'b1;
    step();
    step();
    chk("R7 level released", {15'd0, irq_req}, 16'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule